// File: doc/BRIEF.md
# Programmable Parallel Port Block

This block gives a processor three 8-bit parallel ports, A, B and C, through one small register window. The processor reaches the block with a one-cycle access. It drives chip select with a read or write strobe, a 2-bit address and an 8-bit write data bus. Read data comes back on the same cycle. Every external line is split into an input, an output value and an output enable, so a pad ring can build the tristate pins outside the block.

A single configuration register sets how each port behaves.

- **Plain mode:** each of ports A and B, and each 4-bit half of port C, is an input or an output on its own.
- **Strobed mode:** port A or port B moves data under a handshake. The port lends one half of port C to the handshake: port A uses C[7:4] and port B uses C[3:0]. In that half, one line is a strobe or acknowledge from the peripheral, one is a status flag the block drives, and one is an interrupt request back to the processor.

In strobed input, the peripheral's strobe captures a byte and the processor's read releases it. In strobed output, the processor's write offers a byte and the peripheral's acknowledge retires it.

Top module: `ppio_top`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every output enable is low, every output value is zero, and reading the configuration register returns 0x00. Reset is asynchronous and active low, and its release is synchronised internally over two clock edges.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration register. The configuration register reads back the last value written to it.
- R3: A register is read or written only in a cycle where `cs` is high together with `rd` or `wr`. A write strobe without chip select changes nothing. `rdata` is 0x00 in every cycle without a selected read.
- R4: Configuration bit 0 makes port A an output and bit 1 makes port B an output (1 = output). An output port drives its write latch with all 8 enables high. An input port has all enables low.
- R5: Reading an output port returns its write latch. Reading a plain-mode input port returns the live input pins.
- R6: Configuration bit 2 makes C[3:0] outputs and bit 3 makes C[7:4] outputs, each half on its own. Reading port C returns the driven value on enabled bits and the input pin on the others.
- R7: Configuration bit 4 puts port A in strobed mode and bit 5 does the same for port B. In the borrowed half of port C:
  - bit 0 is the peripheral's strobe or acknowledge input (enable low);
  - bit 1 drives the full or ready flag;
  - bit 2 drives the interrupt request;
  - bit 3 stays a general line under that half's direction bit.
- R8: In strobed input, a rising edge of the strobe loads the port pins into a holding register and sets the full flag. A processor read returns the held byte and clears both the flag and the interrupt. If a strobe edge and a read fall in the same cycle, the flag stays set.
- R9: In strobed output, a processor write sets the ready flag and clears the interrupt. A rising acknowledge while ready is set clears ready and raises the interrupt when it is enabled. A write wins over an acknowledge in the same cycle.
- R10: Configuration bit 6 enables port A's interrupt and bit 7 enables port B's. With the enable at 0, the interrupt output stays low.
- R11: Any write to the configuration register clears both handshake flags and both interrupt requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench targets the same-cycle collisions: a strobe edge meeting a read, and a write meeting an acknowledge. A design with the priority reversed would lose a freshly captured byte, or drop a pending output byte. It drives a strobe that is held high and one that rises while the port is in plain mode. A level-sensitive design would capture repeatedly or raise a stale flag. It also checks that a configuration write clears live flags, that an interrupt stays low when its enable is off, and that mixed-direction reads of port C take each bit from the right source. A swapped half or a missing enable gate shows up at once in the model comparison that runs every clock.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int DW = 8;
  localparam int HW = DW / 2;

  typedef struct packed {
    logic ie_b;
    logic ie_a;
    logic hs_b;
    logic hs_a;
    logic chi_out;
    logic clo_out;
    logic b_out;
    logic a_out;
  } cfg_t;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CFG = 2'd3
  } sel_e;
endpackage

// File: rtl/ppio_cfg.sv
module ppio_cfg
  import ppio_pkg::*;
#(
  parameter int DW_P = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            clat_wr,
  input  logic [DW_P-1:0] wdata,
  output cfg_t            cfg_q,
  output logic [DW_P-1:0] clat_q
);
  cfg_t            cfg_n;
  logic [DW_P-1:0] clat_n;

  always_comb begin
    cfg_n  = cfg_q;
    clat_n = clat_q;
    if (cfg_wr)  cfg_n  = cfg_t'(wdata[7:0]);
    if (clat_wr) clat_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      clat_q <= '0;
    end else begin
      if (cfg_wr)  cfg_q  <= cfg_n;
      if (clat_wr) clat_q <= clat_n;
    end
  end
endmodule

// File: rtl/ppio_hsport.sv
module ppio_hsport #(
  parameter int DW_P = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_en,
  input  logic            dir_out,
  input  logic            ie,
  input  logic            wr_sel,
  input  logic            rd_sel,
  input  logic            cfg_wr,
  input  logic [DW_P-1:0] wdata,
  input  logic [DW_P-1:0] pin_in,
  input  logic            stb_pin,
  output logic [DW_P-1:0] out_q,
  output logic [DW_P-1:0] rd_val,
  output logic            flag_q,
  output logic            irq_q
);
  logic [DW_P-1:0] in_q;
  logic            stb_q;
  logic            ev;
  logic            flag_n, irq_n;
  logic            out_en, in_en;

  assign ev     = stb_pin & ~stb_q;
  assign out_en = wr_sel;
  assign in_en  = hs_en & ~dir_out & ev & ~cfg_wr;

  always_comb begin
    flag_n = flag_q;
    irq_n  = irq_q;
    if (cfg_wr || !hs_en) begin
      flag_n = 1'b0;
      irq_n  = 1'b0;
    end else if (!dir_out) begin
      if (ev) begin
        flag_n = 1'b1;
        irq_n  = ie;
      end else if (rd_sel) begin
        flag_n = 1'b0;
        irq_n  = 1'b0;
      end
    end else begin
      if (wr_sel) begin
        flag_n = 1'b1;
        irq_n  = 1'b0;
      end else if (ev && flag_q) begin
        flag_n = 1'b0;
        irq_n  = ie;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      in_q   <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      if (out_en) out_q <= wdata;
      if (in_en)  in_q  <= pin_in;
      flag_q <= flag_n;
      irq_q  <= irq_n;
      stb_q  <= stb_pin;
    end
  end

  assign rd_val = dir_out ? out_q : (hs_en ? in_q : pin_in);
endmodule

// File: rtl/ppio_cnib.sv
module ppio_cnib #(
  parameter int HW_P = 4
) (
  input  logic            hs_en,
  input  logic            gen_out,
  input  logic            flag,
  input  logic            irq,
  input  logic [HW_P-1:0] lat,
  output logic [HW_P-1:0] oe,
  output logic [HW_P-1:0] dout
);
  for (genvar k = 0; k < HW_P; k++) begin : g_bit
    if (k == 0) begin : g_stb
      assign oe[k]   = ~hs_en & gen_out;
      assign dout[k] = hs_en ? 1'b0 : lat[k];
    end else if (k == 1) begin : g_flag
      assign oe[k]   = hs_en | gen_out;
      assign dout[k] = hs_en ? flag : lat[k];
    end else if (k == 2) begin : g_irq
      assign oe[k]   = hs_en | gen_out;
      assign dout[k] = hs_en ? irq : lat[k];
    end else begin : g_gen
      assign oe[k]   = gen_out;
      assign dout[k] = lat[k];
    end
  end
endmodule

// File: rtl/ppio_top.sv
module ppio_top
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic acc_wr, acc_rd, cfg_wr, clat_wr;
  sel_e sel;
  cfg_t cfg_q;
  logic [DW-1:0] clat_q;

  assign sel     = sel_e'(addr);
  assign acc_wr  = cs & wr;
  assign acc_rd  = cs & rd;
  assign cfg_wr  = acc_wr & (sel == SEL_CFG);
  assign clat_wr = acc_wr & (sel == SEL_C);

  ppio_cfg #(.DW_P(DW)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .clat_wr(clat_wr),
    .wdata(wdata), .cfg_q(cfg_q), .clat_q(clat_q)
  );

  logic [1:0]          hs_v, dir_v, ie_v, stb_v, wr_v, rd_v, flag_v, irq_v, hlf_v;
  logic [1:0][DW-1:0]  pin_v, out_v, rdv_v;
  logic [1:0][HW-1:0]  nib_oe, nib_do;

  assign hs_v  = {cfg_q.hs_b, cfg_q.hs_a};
  assign dir_v = {cfg_q.b_out, cfg_q.a_out};
  assign ie_v  = {cfg_q.ie_b, cfg_q.ie_a};
  assign hlf_v = {cfg_q.chi_out, cfg_q.clo_out};
  assign stb_v = {pc_i[0], pc_i[HW]};
  assign pin_v = {pb_i, pa_i};

  for (genvar i = 0; i < 2; i++) begin : g_port
    localparam int NI = 1 - i;
    assign wr_v[i] = acc_wr & (addr == 2'(i));
    assign rd_v[i] = acc_rd & (addr == 2'(i));

    ppio_hsport #(.DW_P(DW)) u_hs (
      .clk(clk), .rst_n(rst_int_n), .hs_en(hs_v[i]), .dir_out(dir_v[i]),
      .ie(ie_v[i]), .wr_sel(wr_v[i]), .rd_sel(rd_v[i]), .cfg_wr(cfg_wr),
      .wdata(wdata), .pin_in(pin_v[i]), .stb_pin(stb_v[i]),
      .out_q(out_v[i]), .rd_val(rdv_v[i]), .flag_q(flag_v[i]), .irq_q(irq_v[i])
    );

    ppio_cnib #(.HW_P(HW)) u_nib (
      .hs_en(hs_v[i]), .gen_out(hlf_v[NI]), .flag(flag_v[i]), .irq(irq_v[i]),
      .lat(clat_q[NI*HW +: HW]), .oe(nib_oe[NI]), .dout(nib_do[NI])
    );
  end

  assign pa_o  = out_v[0];
  assign pa_oe = {DW{cfg_q.a_out}};
  assign pb_o  = out_v[1];
  assign pb_oe = {DW{cfg_q.b_out}};
  assign pc_o  = nib_do;
  assign pc_oe = nib_oe;

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_A:   rd_mux = rdv_v[0];
      SEL_B:   rd_mux = rdv_v[1];
      SEL_C:   rd_mux = (pc_oe & pc_o) | (~pc_oe & pc_i);
      default: rd_mux = cfg_q;
    endcase
  end
  assign rdata = acc_rd ? rd_mux : '0;
endmodule

// File: rtl/ppio_chk.sv
module ppio_chk
  import ppio_pkg::*;
(
  input logic          clk,
  input logic          rst_int_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pc_i,
  input cfg_t          cfg,
  input logic          flag_a,
  input logic          flag_b,
  input logic          irq_a,
  input logic          irq_b
);
  p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cs && rd) |-> rdata == '0);

  p_dir_a_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs && wr && addr == 2'd3) |=> pa_oe == {DW{$past(wdata[0])}});

  p_full_set_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(pc_i[HW]) && cfg.hs_a && !cfg.a_out && !(cs && wr && addr == 2'd3)) |=> flag_a);

  p_ready_set_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs && wr && addr == 2'd0 && cfg.hs_a && cfg.a_out) |=> (flag_a && !irq_a));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg.ie_a |-> !irq_a) and (!cfg.ie_b |-> !irq_b));

  p_cfg_clear_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs && wr && addr == 2'd3) |=> !flag_a && !flag_b && !irq_a && !irq_b);
endmodule

bind ppio_top ppio_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pa_oe(pa_oe), .pc_i(pc_i), .cfg(cfg_q),
  .flag_a(flag_v[0]), .flag_b(flag_v[1]), .irq_a(irq_v[0]), .irq_b(irq_v[1])
);

// File: tb/ppio_top_test.sv
module ppio_top_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
  logic [7:0] rdata, pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ppio_top uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe), .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
  );

  // behavioural reference model
  bit [7:0] m_ctrl;
  bit [7:0] m_lat [3];
  bit [7:0] m_in  [2];
  bit       m_flag[2];
  bit       m_irq [2];
  bit       m_stbq[2];

  function automatic bit stb_of(int i);
    return (i == 0) ? pc_i[4] : pc_i[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int i = 0; i < 3; i++) m_lat[i] = 0;
      for (int i = 0; i < 2; i++) begin
        m_in[i] = 0; m_flag[i] = 0; m_irq[i] = 0; m_stbq[i] = 0;
      end
    end else begin
      bit cw;
      cw = cs && wr && addr == 2'd3;
      for (int i = 0; i < 2; i++) begin
        bit ev, ws, rs, hs, o, ie;
        ev = stb_of(i) && !m_stbq[i];
        ws = cs && wr && addr == 2'(i);
        rs = cs && rd && addr == 2'(i);
        hs = m_ctrl[4+i]; o = m_ctrl[i]; ie = m_ctrl[6+i];
        if (cw || !hs) begin
          m_flag[i] = 0; m_irq[i] = 0;
        end else if (!o) begin
          if (ev) begin
            m_in[i] = (i == 0) ? pa_i : pb_i; m_flag[i] = 1; m_irq[i] = ie;
          end else if (rs) begin
            m_flag[i] = 0; m_irq[i] = 0;
          end
        end else if (ws) begin
          m_flag[i] = 1; m_irq[i] = 0;
        end else if (ev && m_flag[i]) begin
          m_flag[i] = 0; m_irq[i] = ie;
        end
        if (ws) m_lat[i] = wdata;
        m_stbq[i] = stb_of(i);
      end
      if (cs && wr && addr == 2'd2) m_lat[2] = wdata;
      if (cw) m_ctrl = wdata;
    end
  end

  function automatic bit [15:0] exp_c();
    bit [7:0] oe, o;
    for (int h = 0; h < 2; h++) begin
      int i;
      bit hs, g;
      i = 1 - h;
      hs = m_ctrl[4+i]; g = m_ctrl[2+h];
      if (hs) begin
        oe[h*4 +: 4] = {g, 1'b1, 1'b1, 1'b0};
        o[h*4 +: 4]  = {m_lat[2][h*4+3], m_irq[i], m_flag[i], 1'b0};
      end else begin
        oe[h*4 +: 4] = {4{g}};
        o[h*4 +: 4]  = m_lat[2][h*4 +: 4];
      end
    end
    return {oe, o};
  endfunction

  function automatic bit [7:0] exp_rd();
    bit [15:0] c;
    if (!(cs && rd)) return 8'h00;
    c = exp_c();
    case (addr)
      2'd0: return m_ctrl[0] ? m_lat[0] : (m_ctrl[4] ? m_in[0] : pa_i);
      2'd1: return m_ctrl[1] ? m_lat[1] : (m_ctrl[5] ? m_in[1] : pb_i);
      2'd2: return (c[15:8] & c[7:0]) | (~c[15:8] & pc_i);
      default: return m_ctrl;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      bit [15:0] c;
      c = exp_c();
      chk("R4", "pa_oe", pa_oe, {8{m_ctrl[0]}});
      chk("R4", "pa_o", pa_o, m_lat[0]);
      chk("R4", "pb_oe", pb_oe, {8{m_ctrl[1]}});
      chk("R4", "pb_o", pb_o, m_lat[1]);
      chk("R7", "pc_oe", pc_oe, c[15:8]);
      chk("R7", "pc_o", pc_o, c[7:0]);
      chk("R2", "rdata", rdata, exp_rd());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    tick(); cs = 1; wr = 1; addr = a; wdata = d;
    tick(); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    tick(); cs = 1; rd = 1; addr = a;
    #(CLK_P/4); d = rdata;
    tick(); cs = 0; rd = 0;
  endtask

  task automatic pulse(input int b);
    tick(); pc_i[b] = 1;
    tick(); pc_i[b] = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    #(CLK_P/4);
    chk("R1", "pa_oe in reset", pa_oe, 8'h00);
    chk("R1", "pc_oe in reset", pc_oe, 8'h00);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();
    cmp_on = 1;
    rd_reg(2'd3, v); chk("R1", "cfg after reset", v, 8'h00);
    chk("R3", "rdata idle", rdata, 8'h00);

    // plain outputs A and B
    wr_reg(2'd3, 8'h03);
    wr_reg(2'd0, 8'h5A);
    wr_reg(2'd1, 8'h3C);
    chk("R4", "pa_o driven", pa_o, 8'h5A);
    chk("R4", "pa_oe all ones", pa_oe, 8'hFF);
    rd_reg(2'd0, v); chk("R5", "read A latch", v, 8'h5A);
    rd_reg(2'd1, v); chk("R5", "read B latch", v, 8'h3C);

    // write strobe without chip select
    tick(); wr = 1; addr = 2'd0; wdata = 8'hFF;
    tick(); wr = 0;
    chk("R3", "no-cs write ignored", pa_o, 8'h5A);

    // port C halves
    wr_reg(2'd3, 8'h04);
    wr_reg(2'd2, 8'hA5);
    pc_i = 8'h70;
    chk("R6", "pc_oe low half", pc_oe, 8'h0F);
    rd_reg(2'd2, v); chk("R6", "mixed C read", v, 8'h75);
    pc_i = 8'h00;

    // plain input
    wr_reg(2'd3, 8'h00);
    pa_i = 8'h81;
    rd_reg(2'd0, v); chk("R5", "read A pins", v, 8'h81);

    // strobed input on A with interrupt
    wr_reg(2'd3, 8'h50);
    pa_i = 8'hC3;
    pulse(4);
    chk("R8", "full flag", {7'd0, pc_o[5]}, 8'h01);
    chk("R10", "irq enabled", {7'd0, pc_o[6]}, 8'h01);
    chk("R7", "hs nibble oe", pc_oe, 8'h60);
    pa_i = 8'h11;
    rd_reg(2'd0, v); chk("R8", "held byte", v, 8'hC3);
    chk("R8", "flag+irq cleared", {6'd0, pc_o[6:5]}, 8'h00);

    // strobe held high: only one capture
    tick(); pa_i = 8'h22; pc_i[4] = 1;
    tick(); pa_i = 8'h33;
    tick(); pc_i[4] = 0;
    rd_reg(2'd0, v); chk("R8", "single edge capture", v, 8'h22);

    // interrupt disabled
    wr_reg(2'd3, 8'h10);
    pulse(4);
    chk("R10", "irq stays low", {7'd0, pc_o[6]}, 8'h00);
    chk("R8", "flag set", {7'd0, pc_o[5]}, 8'h01);
    wr_reg(2'd3, 8'h10);
    chk("R11", "cfg write clears flag", {7'd0, pc_o[5]}, 8'h00);

    // strobe and read collide
    tick(); cs = 1; rd = 1; addr = 2'd0; pc_i[4] = 1; pa_i = 8'h44;
    tick(); cs = 0; rd = 0; pc_i[4] = 0;
    chk("R8", "strobe wins over read", {7'd0, pc_o[5]}, 8'h01);

    // strobed output on B with interrupt
    wr_reg(2'd3, 8'hA2);
    wr_reg(2'd1, 8'h96);
    chk("R9", "ready set", {7'd0, pc_o[1]}, 8'h01);
    chk("R9", "pb_o", pb_o, 8'h96);
    pulse(0);
    chk("R9", "ready cleared", {7'd0, pc_o[1]}, 8'h00);
    chk("R9", "irq raised", {7'd0, pc_o[2]}, 8'h01);
    wr_reg(2'd1, 8'h69);
    chk("R9", "write clears irq", {6'd0, pc_o[2:1]}, 8'h01);
    // acknowledge and write collide
    tick(); cs = 1; wr = 1; addr = 2'd1; wdata = 8'h77; pc_i[0] = 1;
    tick(); cs = 0; wr = 0; pc_i[0] = 0;
    chk("R9", "write wins over ack", {6'd0, pc_o[2:1]}, 8'h01);
    rd_reg(2'd2, v); chk("R7", "C read shows flags", v & 8'h06, 8'h02);
    wr_reg(2'd3, 8'hA2);
    chk("R11", "cfg write clears ready", {6'd0, pc_o[2:1]}, 8'h00);

    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule